// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of up to sixteen serial transfers without help from the host. Three small internal memories hold, for each queue entry, the word to send, the word received and a command word whose chip-select field picks which of four active-low selects is driven during that entry. The host fills the memories through an address register and a data register, sets up a mode register (word width and clock divider) and a wrap register (first and last queue entry), and sets the enable bit.

The controller then walks the entries from the first pointer to the last, wrapping from entry 15 to entry 0 if needed. For each entry it drives the selects from the command word, shifts the low bits of the transmit word out MSB first while sampling the input line, and stores the received bits in the matching receive entry. When the last entry is stored, the selects return high, the enable bit clears itself and a completion flag is raised. The flag can raise an interrupt line and is cleared by writing one to it.

Top module: `qspi_master`

## Requirements
- R1: After reset all four chip selects are high, the serial clock and data output are low, the interrupt output is low, and the mode, enable, status, wrap and address registers read zero.
- R2: The data register reaches memory at the address register value: 0x00-0x0F transmit, 0x10-0x1F receive, 0x20-0x2F command (address bits 5:4 pick the region, bits 3:0 the entry). Every data register read or write adds one to the address register. Host writes into the receive region are ignored.
- R3: The wrap register holds the last entry in bits 11:8 and the first entry in bits 3:0; the queue runs first, first+1, ... modulo 16 up to and including last, and no other entry is transferred.
- R4: Mode bits 13:10 set the word width (0 means 16 bits, otherwise that many bits); only the low width bits of a transmit entry are sent, most significant of them first.
- R5: The serial clock idles low; each half period lasts B system clocks where B is mode bits 7:0 (0 behaves as 1); the data output changes on falling edges and the input is sampled on rising edges.
- R6: During an entry the chip-select outputs equal bits 11:8 of its command word (bit 8 drives select 0) and stay constant for the whole entry; when the queue is not running all selects are high.
- R7: Writing 1 to enable bit 0 (select 1) while idle starts the queue; the bit reads 1 while the queue runs and clears itself when the queue ends.
- R8: Status bit 0 is set when the last entry has been stored and is cleared by writing 1 to it (writing 0 leaves it); status bit 8 is a read/write interrupt enable, and the interrupt output is high exactly while both are 1.
- R9: After entry n finishes, receive entry n holds the bits sampled during that entry, right aligned, with all bits above the width reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Register select: 0 mode, 1 enable, 2 status, 3 wrap, 4 address, 5 data |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (advances the address on data reads) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register, same cycle |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
Register reads are combinational, so the bench samples read data in the same cycle a strobe is applied, and the address increment is seen from the following cycle. Each entry takes a load and a store cycle plus (2N+1)·B system clocks for N bits, so the first rising serial edge comes B clocks after the load and the completion flag appears one cycle after the last entry's final half period; the bench does not count these cycles but follows the serial clock, sampling the data output and selects one time step after each rising edge and changing its input one step after each falling edge. A scoreboard queue filled before enable is emptied by the serial monitor, and the high half period is timed against B; the completion flag is polled, then the receive memory and status are read back.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int QP_DATA_W = 16;
    localparam int QP_PTR_W  = 4;
    localparam int QP_CS_W   = 4;
    localparam int QP_CS_LSB = 8;
    localparam int QP_BAUD_W = 8;
    localparam int QP_WID_W  = 4;
    localparam int QP_CNT_W  = $clog2(QP_DATA_W) + 1;
    localparam int QP_NRGN   = 3;

    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_CTRL  = 3'd1;
    localparam logic [2:0] SEL_STAT  = 3'd2;
    localparam logic [2:0] SEL_WRAP  = 3'd3;
    localparam logic [2:0] SEL_RADDR = 3'd4;
    localparam logic [2:0] SEL_RDATA = 3'd5;

    localparam logic [1:0] RGN_TX  = 2'd0;
    localparam logic [1:0] RGN_RX  = 2'd1;
    localparam logic [1:0] RGN_CMD = 2'd2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LOAD  = 2'd1,
        ENG_SHIFT = 2'd2,
        ENG_STORE = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic [QP_WID_W-1:0]  width;
        logic [QP_BAUD_W-1:0] baud;
    } mode_t;

    typedef struct packed {
        logic [QP_PTR_W-1:0] last;
        logic [QP_PTR_W-1:0] first;
    } wrap_t;

    function automatic logic [QP_CNT_W-1:0] bits_of(input logic [QP_WID_W-1:0] f);
        if (f == '0) return QP_CNT_W'(QP_DATA_W);
        return QP_CNT_W'(f);
    endfunction

    function automatic logic [QP_DATA_W-1:0] low_mask(input logic [QP_CNT_W-1:0] n);
        logic [QP_DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < QP_DATA_W; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [QP_DATA_W-1:0] align_msb(input logic [QP_DATA_W-1:0] w,
                                                       input logic [QP_CNT_W-1:0] n);
        return w << (QP_DATA_W - int'(n));
    endfunction

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/qspi_baud.sv
module qspi_baud #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
#(
    parameter int DW  = QP_DATA_W,
    parameter int PW  = QP_PTR_W,
    parameter int CSW = QP_CS_W,
    parameter int CSL = QP_CS_LSB,
    parameter int CW  = QP_CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PW-1:0]  first_ptr,
    input  logic [PW-1:0]  last_ptr,
    input  logic [CW-1:0]  nbits,
    input  logic           tick,
    input  logic [DW-1:0]  tx_word,
    input  logic [DW-1:0]  cmd_word,
    input  logic           miso,
    output logic [PW-1:0]  ptr,
    output logic           rx_we,
    output logic [DW-1:0]  rx_wdata,
    output logic           busy,
    output logic           run,
    output logic           done_pulse,
    output logic           sck,
    output logic           mosi,
    output logic [CSW-1:0] cs_n
);
    localparam int HW = CW + 1;

    eng_state_e     state;
    logic [PW-1:0]  last_q;
    logic [CW-1:0]  n_q;
    logic [HW-1:0]  half;
    logic [DW-1:0]  tx_sh;
    logic [DW-1:0]  rx_sh;
    logic [DW-1:0]  load_word;
    logic           final_half;
    logic           at_last;

    assign load_word  = align_msb(tx_word, nbits);
    assign final_half = (half == {n_q, 1'b0});
    assign at_last    = (ptr == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            ptr    <= '0;
            last_q <= '0;
            n_q    <= '0;
            half   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            cs_n   <= '1;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        ptr    <= first_ptr;
                        last_q <= last_ptr;
                        state  <= ENG_LOAD;
                    end
                end
                ENG_LOAD: begin
                    n_q   <= nbits;
                    tx_sh <= load_word;
                    mosi  <= load_word[DW-1];
                    rx_sh <= '0;
                    half  <= '0;
                    sck   <= 1'b0;
                    cs_n  <= cmd_word[CSL +: CSW];
                    state <= ENG_SHIFT;
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        if (final_half) begin
                            state <= ENG_STORE;
                        end else begin
                            half <= half + 1'b1;
                            if (!half[0]) begin
                                sck   <= 1'b1;
                                rx_sh <= {rx_sh[DW-2:0], miso};
                            end else begin
                                sck   <= 1'b0;
                                tx_sh <= tx_sh << 1;
                                mosi  <= tx_sh[DW-2];
                            end
                        end
                    end
                end
                ENG_STORE: begin
                    if (at_last) begin
                        state <= ENG_IDLE;
                        cs_n  <= '1;
                        mosi  <= 1'b0;
                    end else begin
                        ptr   <= ptr + 1'b1;
                        state <= ENG_LOAD;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ENG_IDLE);
        run        = (state == ENG_SHIFT);
        rx_we      = (state == ENG_STORE);
        rx_wdata   = rx_sh & low_mask(n_q);
        done_pulse = (state == ENG_STORE) && at_last;
    end
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           host_sel,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [QP_DATA_W-1:0] host_wdata,
    output logic [QP_DATA_W-1:0] host_rdata,
    output logic                 irq,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso,
    output logic [QP_CS_W-1:0]   cs_n
);
    localparam int DW = QP_DATA_W;
    localparam int PW = QP_PTR_W;
    localparam int AW = PW + 2;

    mode_t          mode_q;
    wrap_t          wrap_q;
    logic [AW-1:0]  raddr_q;
    logic           done_q;
    logic           ie_q;

    logic           eng_busy;
    logic           eng_run;
    logic           eng_done;
    logic           eng_rx_we;
    logic [DW-1:0]  eng_rx_wdata;
    logic [PW-1:0]  eng_ptr;
    logic           baud_tick;
    logic           start;

    logic           wr_mode, wr_ctrl, wr_stat, wr_wrap, wr_raddr, data_wr, data_acc;
    logic [1:0]     rgn;
    logic [DW-1:0]  rgn_host_rd [QP_NRGN];
    logic [DW-1:0]  rgn_eng_rd  [QP_NRGN];

    assign rgn      = raddr_q[AW-1 -: 2];
    assign wr_mode  = host_wr && (host_sel == SEL_MODE);
    assign wr_ctrl  = host_wr && (host_sel == SEL_CTRL);
    assign wr_stat  = host_wr && (host_sel == SEL_STAT);
    assign wr_wrap  = host_wr && (host_sel == SEL_WRAP);
    assign wr_raddr = host_wr && (host_sel == SEL_RADDR);
    assign data_wr  = host_wr && (host_sel == SEL_RDATA);
    assign data_acc = (host_wr || host_rd) && (host_sel == SEL_RDATA);
    assign start    = wr_ctrl && host_wdata[0] && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            wrap_q  <= '0;
            raddr_q <= '0;
            done_q  <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_q.width <= host_wdata[10 +: QP_WID_W];
                mode_q.baud  <= host_wdata[0 +: QP_BAUD_W];
            end
            if (wr_wrap) begin
                wrap_q.last  <= host_wdata[8 +: PW];
                wrap_q.first <= host_wdata[0 +: PW];
            end
            if (wr_raddr)      raddr_q <= host_wdata[AW-1:0];
            else if (data_acc) raddr_q <= raddr_q + 1'b1;
            if (wr_stat) ie_q <= host_wdata[8];
            if (eng_done)                       done_q <= 1'b1;
            else if (wr_stat && host_wdata[0])  done_q <= 1'b0;
        end
    end

    assign irq = done_q && ie_q;

    for (genvar g = 0; g < QP_NRGN; g++) begin : g_rgn
        if (g == int'(RGN_RX)) begin : g_rx
            qspi_ram #(.DW(DW), .AW(PW)) u_ram (
                .clk     (clk),
                .we      (eng_rx_we),
                .waddr   (eng_ptr),
                .wdata   (eng_rx_wdata),
                .raddr_a (raddr_q[PW-1:0]),
                .raddr_b (eng_ptr),
                .rdata_a (rgn_host_rd[g]),
                .rdata_b (rgn_eng_rd[g])
            );
        end else begin : g_host
            qspi_ram #(.DW(DW), .AW(PW)) u_ram (
                .clk     (clk),
                .we      (data_wr && (rgn == 2'(g))),
                .waddr   (raddr_q[PW-1:0]),
                .wdata   (host_wdata),
                .raddr_a (raddr_q[PW-1:0]),
                .raddr_b (eng_ptr),
                .rdata_a (rgn_host_rd[g]),
                .rdata_b (rgn_eng_rd[g])
            );
        end
    end

    qspi_baud #(.W(QP_BAUD_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_run),
        .div  (mode_q.baud),
        .tick (baud_tick)
    );

    qspi_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .first_ptr  (wrap_q.first),
        .last_ptr   (wrap_q.last),
        .nbits      (bits_of(mode_q.width)),
        .tick       (baud_tick),
        .tx_word    (rgn_eng_rd[RGN_TX]),
        .cmd_word   (rgn_eng_rd[RGN_CMD]),
        .miso       (miso),
        .ptr        (eng_ptr),
        .rx_we      (eng_rx_we),
        .rx_wdata   (eng_rx_wdata),
        .busy       (eng_busy),
        .run        (eng_run),
        .done_pulse (eng_done),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_MODE:  host_rdata = {2'b00, mode_q.width, 2'b00, mode_q.baud};
            SEL_CTRL:  host_rdata = DW'(eng_busy);
            SEL_STAT:  host_rdata = {7'b0, ie_q, 7'b0, done_q};
            SEL_WRAP:  host_rdata = {4'b0, wrap_q.last, 4'b0, wrap_q.first};
            SEL_RADDR: host_rdata = DW'(raddr_q);
            SEL_RDATA: host_rdata = (rgn == 2'd3) ? '0 : rgn_host_rd[rgn];
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       sck,
    input logic [3:0] cs_n,
    input logic       tick,
    input logic       done,
    input logic       irq,
    input logic       ie
);
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n == 4'hF)) else $error("idle selects not high"); // R6

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck) else $error("idle clock not low"); // R5

    AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(sck) |-> $past(tick)) else $error("clock edge off divider"); // R5

    AST_CS_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(cs_n)) else $error("selects moved mid entry"); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy) else $error("done while running"); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && ie)) else $error("interrupt without cause"); // R8
endmodule

bind qspi_master qspi_master_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (eng_busy),
    .sck  (sck),
    .cs_n (cs_n),
    .tick (baud_tick),
    .done (done_q),
    .irq  (irq),
    .ie   (ie_q)
);

// File: tb/sim_qspi_master.sv
module sim_qspi_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq, sck, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    always #10 clk = ~clk;

    qspi_master u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int tests = 0;
    int fails = 0;

    typedef struct { logic [15:0] word; logic [3:0] csn; } exp_t;
    exp_t exp_q[$];

    logic [15:0] tx_model  [16];
    logic [15:0] cmd_model [16];
    logic [15:0] rx_exp    [16];
    bit          rx_valid  [16];
    int          k_next   = 0;
    int          cur_bits = 16;
    int          cur_baud = 1;

    int          s_cnt = 0;
    int          s_idx = 0;
    logic [15:0] s_word = '0;
    logic [15:0] m_sh = '0;
    time         t_rise = 0;

    function automatic logic [15:0] slave_word(input int k);
        return 16'((k + 1) * 40503) ^ 16'(k * 300);
    endfunction

    function automatic logic [15:0] bmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // serial slave and scoreboard monitor
    always @(posedge sck) begin
        t_rise = $time;
        #1;
        m_sh = {m_sh[14:0], mosi};
        s_cnt++;
        if (s_cnt == cur_bits) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected transfer", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R4 serial word", 32'(m_sh & bmask(cur_bits)), 32'(e.word));
                check("R6 selects during entry", 32'(cs_n), 32'(e.csn));
            end
        end
    end

    always @(negedge sck) begin
        #1;
        if (s_cnt == 1) check("R5 high half period", 32'(($time - 1 - t_rise) / 20), 32'(cur_baud));
        if (s_cnt == cur_bits) begin
            s_cnt = 0;
            s_idx++;
            s_word = slave_word(s_idx);
        end
        miso = s_word[cur_bits - 1 - s_cnt];
    end

    task automatic run_queue(input int first, input int last, input int wfield, input int baud);
        logic [15:0] d;
        int p;
        int polls;
        cur_bits = (wfield == 0) ? 16 : wfield;
        cur_baud = (baud == 0) ? 1 : baud;
        reg_write(3'd0, 16'((wfield << 10) | baud));
        reg_write(3'd3, 16'((last << 8) | first));
        p = first;
        forever begin
            exp_t e;
            e.word = tx_model[p] & bmask(cur_bits);
            e.csn  = cmd_model[p][11:8];
            exp_q.push_back(e);
            rx_exp[p]   = slave_word(k_next) & bmask(cur_bits);
            rx_valid[p] = 1'b1;
            k_next++;
            if (p == last) break;
            p = (p + 1) % 16;
        end
        s_cnt  = 0;
        m_sh   = '0;
        s_word = slave_word(s_idx);
        miso   = s_word[cur_bits - 1];
        reg_write(3'd1, 16'h0001);
        reg_read(3'd1, d);
        check("R7 enable reads 1 while running", 32'(d[0]), 1);
        polls = 0;
        do begin
            reg_read(3'd2, d);
            polls++;
        end while (!d[0] && polls < 20000);
        check("R8 done flag set", 32'(d[0]), 1);
        check("R3 all queued entries seen", 32'(exp_q.size()), 0);
        reg_read(3'd1, d);
        check("R7 enable self clears", 32'(d[0]), 0);
        check("R6 selects high after queue", 32'(cs_n), 32'hF);
    endtask

    task automatic sweep_rx(input string tag);
        logic [15:0] d;
        reg_write(3'd4, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            reg_read(3'd5, d);
            if (rx_valid[i]) check(tag, 32'(d), 32'(rx_exp[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        for (int i = 0; i < 16; i++) begin
            tx_model[i]  = 16'h5A3C ^ 16'(i * 16'h1111);
            cmd_model[i] = {4'h7, ~(4'b0001 << (i / 4)), 8'h00};
            rx_valid[i]  = 1'b0;
        end
        cmd_model[15] = 16'h0A00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset selects", 32'(cs_n), 32'hF);
        check("R1 reset sck/mosi/irq", 32'({sck, mosi, irq}), 0);
        reg_read(3'd0, d); check("R1 reset mode", 32'(d), 0);
        reg_read(3'd2, d); check("R1 reset status", 32'(d), 0);
        reg_read(3'd3, d); check("R1 reset wrap", 32'(d), 0);
        reg_read(3'd4, d); check("R1 reset address", 32'(d), 0);

        reg_write(3'd4, 16'h0000);
        for (int i = 0; i < 16; i++) reg_write(3'd5, tx_model[i]);
        reg_read(3'd4, d); check("R2 address after tx fill", 32'(d), 32'h10);
        reg_write(3'd4, 16'h0020);
        for (int i = 0; i < 16; i++) reg_write(3'd5, cmd_model[i]);
        reg_read(3'd4, d); check("R2 address after cmd fill", 32'(d), 32'h30);
        reg_write(3'd4, 16'h0005);
        reg_read(3'd5, d); check("R2 tx readback", 32'(d), 32'(tx_model[5]));
        reg_read(3'd4, d); check("R2 read increments", 32'(d), 32'h6);
        reg_write(3'd4, 16'h0022);
        reg_read(3'd5, d); check("R2 cmd readback", 32'(d), 32'(cmd_model[2]));

        reg_write(3'd2, 16'h0100);
        run_queue(0, 15, 12, 2);
        #1 check("R8 irq with enable", 32'(irq), 1);
        sweep_rx("R9 receive entries run 1");

        reg_write(3'd4, 16'h0013);
        reg_write(3'd5, 16'hFFFF);
        reg_write(3'd4, 16'h0013);
        reg_read(3'd5, d); check("R2 rx host write ignored", 32'(d), 32'(rx_exp[3]));

        reg_write(3'd2, 16'h0100);
        reg_read(3'd2, d); check("R8 write 0 keeps done", 32'(d), 32'h0101);
        reg_write(3'd2, 16'h0101);
        reg_read(3'd2, d); check("R8 w1c clears done", 32'(d), 32'h0100);
        #1 check("R8 irq low after clear", 32'(irq), 0);

        run_queue(14, 1, 0, 3);
        reg_write(3'd2, 16'h0001);
        #1 check("R8 irq low with enable off", 32'(irq), 0);
        run_queue(7, 7, 5, 0);
        sweep_rx("R3 R9 receive entries after wrap runs");
        reg_read(3'd0, d); check("R4 mode readback", 32'(d), 32'(5 << 10));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule